// File: doc/BRIEF.md
# Output Driver Impedance Calibration Stepper

This block holds the digital strength code of a binary-weighted output driver and moves it slowly toward the value an external analog comparator asks for. A free-running counter opens an evaluation slot once every 64 clocks. In each slot a pending code takes at most one step toward the comparator's target. The pending code only reaches the drivers while the data outputs float, so the driver strength never changes while a value is being driven onto the bus.

Three kinds of bus cycle leave the outputs floating: a write, a deselect, and a cycle with the output enable held off. The surrounding memory controller reports each of these on its own input, and any one of them opens a transfer window for that clock. After reset the block also counts a settle period of 4096 clocks. The first float window that starts after that period marks the code as trustworthy. That condition is reported on a sticky ready flag.

Top module: `zq_step_ctrl`

## Requirements
- R1: An evaluation happens on every 64th rising clock edge after reset is released, with the first on the 64th edge. The pending code changes on no other edge.
- R2: At an evaluation, the pending code rises by one if it is below the target and falls by one if it is above. If it equals the target, it is left unchanged.
- R3: The code is 5 bits wide and covers 32 strength levels, 0 to 31. It never wraps: it stays at 31 when the target is 31 and stays at 0 when the target is 0.
- R4: On each rising edge where write_cyc, deselect_cyc or oe_high is sampled high, drv_code takes the value that pend_code held before that edge. On every other edge, drv_code holds its value.
- R5: If several evaluations occur before a window opens, only the latest pending code reaches drv_code. A window that opens while pend_code already equals drv_code leaves drv_code unchanged.
- R6: cal_ready rises on the first edge on which three conditions hold: at least 4096 edges have already passed since reset release, a window input is high, and no window input was high on the previous edge. Once set, cal_ready stays high until reset. A window that is already open when reset is released does not count as a transition, and neither does a window held open across the 4096-edge boundary.
- R7: While rst_n is low, drv_code and pend_code are 16 and cal_ready is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| target_code | input | 5 | Code requested by the external comparator |
| write_cyc | input | 1 | Current cycle is a write (outputs float) |
| deselect_cyc | input | 1 | Current cycle is a deselect (outputs float) |
| oe_high | input | 1 | Output enable held off around this edge (outputs float) |
| drv_code | output | 5 | Strength code applied to the output drivers |
| pend_code | output | 5 | Code computed by the latest evaluation |
| cal_ready | output | 1 | Calibration settled (sticky) |

## Verification
The hardest case to reach is the ready flag near the end of the settle period. The float window must be held open across the 4096-edge boundary and then must drop and rise again, so that a held window is shown to be different from a fresh transition. The stimulus fills the settle period with two long saturation runs, one to 31 and one to 0. It opens an early window that must not set ready, then holds the output enable off past edge 4096 before releasing it and raising it again. Stacked evaluations are reached by keeping every window closed across several 64-cycle slots.

// File: rtl/zq_step_ctrl.sv
`timescale 1ns/1ps
module zq_step_ctrl #(
  parameter int CODE_W        = 5,
  parameter int EVAL_CYCLES   = 64,
  parameter int SETTLE_CYCLES = 4096,
  parameter int RESET_CODE    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] target_code,
  input  logic              write_cyc,
  input  logic              deselect_cyc,
  input  logic              oe_high,
  output logic [CODE_W-1:0] drv_code,
  output logic [CODE_W-1:0] pend_code,
  output logic              cal_ready
);
  localparam int EC_W = $clog2(EVAL_CYCLES);
  localparam int ST_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [EC_W-1:0]   EVAL_LAST  = EC_W'(EVAL_CYCLES - 1);
  localparam logic [ST_W-1:0]   SETTLE_END = ST_W'(SETTLE_CYCLES);
  localparam logic [CODE_W-1:0] CODE_MAX   = '1;
  localparam logic [CODE_W-1:0] CODE_RST   = CODE_W'(RESET_CODE);

  logic [EC_W-1:0] eval_cnt;
  logic [ST_W-1:0] settle_cnt;
  logic            hiz_q;

  wire eval_tick = (eval_cnt == EVAL_LAST);
  wire settled   = (settle_cnt == SETTLE_END);
  wire hiz       = write_cyc | deselect_cyc | oe_high;
  wire hiz_rise  = hiz & ~hiz_q;
  wire step_up   = (pend_code < target_code) && (pend_code != CODE_MAX);
  wire step_dn   = (pend_code > target_code) && (pend_code != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eval_cnt   <= '0;
      settle_cnt <= '0;
    end else begin
      eval_cnt <= eval_tick ? '0 : eval_cnt + 1'b1;
      if (!settled) settle_cnt <= settle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_code <= CODE_RST;
      drv_code  <= CODE_RST;
      hiz_q     <= 1'b1;
      cal_ready <= 1'b0;
    end else begin
      if (eval_tick && step_up) pend_code <= pend_code + 1'b1;
      else if (eval_tick && step_dn) pend_code <= pend_code - 1'b1;
      if (hiz) drv_code <= pend_code;
      hiz_q <= hiz;
      if (settled && hiz_rise) cal_ready <= 1'b1;
    end
  end

  p_eval_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_tick |=> $stable(pend_code));
  p_one_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend_code == $past(pend_code)) || (pend_code == $past(pend_code) + 1'b1)
             || (pend_code == $past(pend_code) - 1'b1));
  p_toward_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_code != $past(pend_code)) |->
      ((pend_code > $past(pend_code)) == ($past(target_code) > $past(pend_code))));
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend_code) == CODE_MAX && pend_code != CODE_MAX) |-> pend_code == CODE_MAX - 1'b1);
  p_hold_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hiz |=> $stable(drv_code));
  p_ready_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cal_ready |=> cal_ready);
  p_ready_settled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_ready) |-> $past(settled));
endmodule

// File: tb/zq_step_ctrl_tb_top.sv
`timescale 1ns/1ps
module zq_step_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] target_code = 5'd16;
  logic write_cyc = 1'b0, deselect_cyc = 1'b0, oe_high = 1'b0;
  logic [4:0] drv_code, pend_code;
  logic cal_ready;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  zq_step_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .target_code(target_code),
    .write_cyc(write_cyc), .deselect_cyc(deselect_cyc), .oe_high(oe_high),
    .drv_code(drv_code), .pend_code(pend_code), .cal_ready(cal_ready));

  // reference model built from the requirements
  int m_edges;
  logic [4:0] m_pend, m_drv;
  logic m_rdy, m_hiz_prev;
  wire m_hiz = write_cyc | deselect_cyc | oe_high;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_edges <= 0; m_pend <= 5'd16; m_drv <= 5'd16; m_rdy <= 1'b0; m_hiz_prev <= 1'b1;
    end else begin
      m_edges <= m_edges + 1;
      if ((m_edges + 1) % 64 == 0)
        m_pend <= (m_pend < target_code) ? m_pend + 5'd1 :
                  (m_pend > target_code) ? m_pend - 5'd1 : m_pend;
      if (m_hiz) m_drv <= m_pend;
      m_hiz_prev <= m_hiz;
      if (m_edges >= 4096 && m_hiz && !m_hiz_prev) m_rdy <= 1'b1;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_window(int which);
    if (which == 0) write_cyc = 1'b1;
    else if (which == 1) deselect_cyc = 1'b1;
    else oe_high = 1'b1;
    cyc(1);
    write_cyc = 1'b0; deselect_cyc = 1'b0; oe_high = 1'b0;
    cyc(1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    cyc(3);
    chk("R7", "drv_code in reset", drv_code, 16);
    chk("R7", "pend_code in reset", pend_code, 16);
    chk("R7", "cal_ready in reset", cal_ready, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_step_up;
    target_code = 5'd20;
    cyc(63);
    chk("R1", "pend before first evaluation", pend_code, 16);
    cyc(1);
    chk("R1", "pend after 64th edge", pend_code, 17);
    cyc(64);
    chk("R2", "pend after two evaluations", pend_code, 18);
    chk("R4", "drv held with windows closed", drv_code, 16);
  endtask

  task automatic t_apply;
    pulse_window(0);
    chk("R4", "drv after write window", drv_code, m_drv);
    chk("R4", "drv equals pending 18", drv_code, 18);
  endtask

  task automatic t_latest;
    cyc(64 * 3);
    chk("R2", "pend holds at target", pend_code, 20);
    chk("R5", "drv unchanged across stacked evaluations", drv_code, 18);
    pulse_window(1);
    chk("R5", "latest pending applied on deselect", drv_code, 20);
    pulse_window(2);
    chk("R5", "window with nothing pending", drv_code, 20);
  endtask

  task automatic t_sat_high;
    target_code = 5'd31;
    cyc(64 * 14);
    chk("R3", "pend saturates at 31", pend_code, 31);
    pulse_window(2);
    chk("R3", "drv at 31", drv_code, 31);
    chk("R6", "no ready before settle period", cal_ready, 0);
  endtask

  task automatic t_sat_low;
    target_code = 5'd0;
    cyc(64 * 34);
    chk("R3", "pend saturates at 0", pend_code, 0);
    chk("R2", "pend matches model", pend_code, m_pend);
    pulse_window(0);
    chk("R3", "drv at 0", drv_code, 0);
  endtask

  task automatic t_ready;
    chk("R6", "not ready yet", cal_ready, 0);
    oe_high = 1'b1;
    while (m_edges < 4200) cyc(1);
    chk("R6", "held window across boundary", cal_ready, 0);
    oe_high = 1'b0;
    cyc(2);
    chk("R6", "still not ready after close", cal_ready, 0);
    oe_high = 1'b1;
    cyc(1);
    oe_high = 1'b0;
    chk("R6", "ready after fresh transition", cal_ready, 1);
    cyc(5);
    chk("R6", "ready sticky", cal_ready, 1);
    chk("R6", "ready matches model", cal_ready, m_rdy);
  endtask

  initial begin
    cyc(1);
    t_reset;
    t_step_up;
    t_apply;
    t_latest;
    t_sat_high;
    t_sat_low;
    t_ready;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4ns * 200000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule